// File: doc/BRIEF.md
# Programmable Wait-State ROM Interface

This block connects a 32-bit host request port to one external parallel flash or ROM bank. The bank can be 8, 16 or 32 bits wide. A control register sets that width and three timing counts: the first-access wait, a shorter wait for sequential reads, and the idle (turnaround) time between accesses. Each count is held in a 4-bit field, where a zero encodes the largest setting of sixteen cycles. At the usual 20 ns clock, a count of 7 gives a 140 ns access.

The host raises a request with an address, a direction and write data, and holds it until a one-cycle ready pulse. During an access the block drives chip-select low, together with output-enable for a read or write-enable for a write. It holds them for the programmed number of cycles and then returns the read data, zero-extended to the bank width. Narrow writes do not take their byte lane from the host address. The lane comes from a separate 2-bit lane register, and the device address is word-aligned. Full-width writes pass the host address through unchanged.

Top module: `waitstate_rom_if`

## Requirements
- R1: After reset the strobes are inactive (`ext_cs_n`, `ext_oe_n`, `ext_we_n` high), `ext_dq_oe` and `hst_ready` are low, the lane register reads 0, and the control register reads 32'h0000_8000: bank width code 2'b10 and all three timing fields 0.
- R2: The width field is control bits [15:14]: 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit. Code 2'b11 sets `cfg_err`. A request made under code 2'b11 raises no strobe and gets `hst_ready` with `hst_err` high and `hst_rdata` zero in the cycle after it is accepted.
- R3: Control bits [19:16] give the access wait A. A non-sequential access holds `ext_cs_n` low for exactly A cycles, and A = 0 means 16 cycles.
- R4: `hst_ready` is a one-cycle pulse in the cycle after the last strobe cycle, and `hst_rdata` is valid in that cycle.
- R5: A read drives the host address unchanged on `ext_addr`. It returns `ext_dq_i[7:0]`, `[15:0]` or `[31:0]` for widths 8, 16 and 32, with the upper bits zero.
- R6: An 8-bit or 16-bit write drives `ext_addr` with bits [1:0] cleared and ignores `hst_addr[1:0]`. The lane register (write data bits [1:0], `reg_sel` = 1) appears on `ext_lane`. An 8-bit write places `hst_wdata[7:0]` on byte lane L of `ext_dq_o`. A 16-bit write places `hst_wdata[15:0]` on the half selected by L[1]. All other data bits are zero.
- R7: A 32-bit write drives `hst_addr` unchanged and all of `hst_wdata`, whatever the lane register holds.
- R8: Control bits [27:24] give the turnaround T (0 means 16). After an access, the next chip-select assertion comes exactly T+1 cycles after the ready cycle when a request is already pending.
- R9: Control bits [23:20] give the burst wait B (0 means 16). A read whose address equals the previous access's address plus the bank width in bytes uses B instead of A, but only when that previous access was a read.
- R10: During a read only `ext_oe_n` is low and `ext_dq_oe` is low. During a write only `ext_we_n` is low and `ext_dq_oe` is high.
- R11: A control write made in the same cycle that a request is accepted changes only later accesses. The accepted access keeps the old timing and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = lane register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the register chosen by reg_sel |
| cfg_err | output | 1 | Width field holds the undefined code |
| hst_req | input | 1 | Host request, held until hst_ready |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | AW | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_ready | output | 1 | One-cycle completion pulse |
| hst_err | output | 1 | Completion without a device access |
| hst_rdata | output | 32 | Read data, zero-extended |
| ext_addr | output | AW | Device address |
| ext_lane | output | 2 | Byte lane of the current narrow write |
| ext_cs_n | output | 1 | Device chip-select, active low |
| ext_oe_n | output | 1 | Device output-enable, active low |
| ext_we_n | output | 1 | Device write-enable, active low |
| ext_dq_o | output | 32 | Data driven toward the device |
| ext_dq_oe | output | 1 | Data bus drive enable |
| ext_dq_i | input | 32 | Data returned by the device |

## Verification
Two functions can land in the same clock edge: a control-register write and the acceptance of a host request. The bench creates this by raising `reg_wr` and `hst_req` in the same cycle while the sequencer is known to be idle. It then counts the chip-select cycles of that access, which must follow the old wait count, and of the access after it, which must follow the new one. A second overlap is a request already pending during the turnaround window. This is judged by the exact cycle count between the ready pulse and the next chip-select assertion.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  localparam int DW      = 32;
  localparam int TF_W    = 4;
  localparam int CNT_W   = TF_W + 1;
  localparam int BW_LSB  = 14;
  localparam int ACC_LSB = 16;
  localparam int BUR_LSB = 20;
  localparam int TRN_LSB = 24;
  localparam int LANE_W  = 2;

  typedef enum logic [1:0] {
    BW_8    = 2'b00,
    BW_16   = 2'b01,
    BW_32   = 2'b10,
    BW_NONE = 2'b11
  } bank_w_e;

  typedef struct packed {
    logic [TF_W-1:0] trn;
    logic [TF_W-1:0] bur;
    logic [TF_W-1:0] acc;
    bank_w_e         bw;
  } tcfg_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_STROBE = 2'b01,
    ST_TURN   = 2'b10
  } seq_st_e;

  // Timing field to cycle count: zero stands for the full sixteen.
  function automatic logic [CNT_W-1:0] span(input logic [TF_W-1:0] f);
    return (f == '0) ? {1'b1, {TF_W{1'b0}}} : {1'b0, f};
  endfunction

  // Bytes moved per beat for a width code.
  function automatic logic [2:0] beat_bytes(input bank_w_e w);
    case (w)
      BW_8:    return 3'd1;
      BW_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/wsr_regs.sv
module wsr_regs
  import wsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output tcfg_t             cfg,
  output logic [LANE_W-1:0] lane,
  output logic              cfg_err
);

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[DW-1:TRN_LSB+TF_W], reg_wdata[BW_LSB-1:LANE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.trn <= '0;
      cfg.bur <= '0;
      cfg.acc <= '0;
      cfg.bw  <= BW_32;
      lane    <= '0;
    end else if (reg_wr) begin
      if (!reg_sel) begin
        cfg.bw  <= bank_w_e'(reg_wdata[BW_LSB +: 2]);
        cfg.acc <= reg_wdata[ACC_LSB +: TF_W];
        cfg.bur <= reg_wdata[BUR_LSB +: TF_W];
        cfg.trn <= reg_wdata[TRN_LSB +: TF_W];
      end else begin
        lane <= reg_wdata[LANE_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_sel) begin
      reg_rdata[BW_LSB +: 2]     = cfg.bw;
      reg_rdata[ACC_LSB +: TF_W] = cfg.acc;
      reg_rdata[BUR_LSB +: TF_W] = cfg.bur;
      reg_rdata[TRN_LSB +: TF_W] = cfg.trn;
    end else begin
      reg_rdata[LANE_W-1:0] = lane;
    end
  end

  assign cfg_err = (cfg.bw == BW_NONE);

  // R1: the lane register only changes through a lane write
  a_r1_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel) |=> $stable(lane));

endmodule

// File: rtl/wsr_steer.sv
module wsr_steer
  import wsr_pkg::*;
#(
  parameter int AW = 24
) (
  input  bank_w_e           bw,
  input  logic [LANE_W-1:0] lane,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     dq_i,
  output logic [AW-1:0]     dev_addr,
  output logic [DW-1:0]     dq_o,
  output logic [DW-1:0]     rd_word
);

  always_comb begin
    dev_addr = addr;
    dq_o     = wdata;
    rd_word  = dq_i;
    case (bw)
      BW_8: begin
        rd_word = {{(DW-8){1'b0}}, dq_i[7:0]};
        if (we) begin
          dev_addr = {addr[AW-1:2], 2'b00};
          dq_o     = '0;
          dq_o[{lane, 3'b000} +: 8] = wdata[7:0];
        end
      end
      BW_16: begin
        rd_word = {{(DW-16){1'b0}}, dq_i[15:0]};
        if (we) begin
          dev_addr = {addr[AW-1:2], 2'b00};
          dq_o     = '0;
          dq_o[{lane[1], 4'b0000} +: 16] = wdata[15:0];
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wsr_fsm.sv
module wsr_fsm
  import wsr_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  tcfg_t             cfg,
  input  logic [LANE_W-1:0] lane,
  input  logic [DW-1:0]     rd_word,
  output logic              strobe,
  output logic              acc_we,
  output logic [AW-1:0]     acc_addr,
  output logic [DW-1:0]     acc_wdata,
  output bank_w_e           acc_bw,
  output logic [LANE_W-1:0] acc_lane,
  output logic              hst_ready,
  output logic              hst_err,
  output logic [DW-1:0]     hst_rdata
);

  localparam int RUN_W = CNT_W + 1;

  seq_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] turn_len;
  logic [AW-1:0]    last_addr;
  logic             last_rd_ok;
  logic             seq_hit;
  logic             accept;
  logic             bad_width;
  logic             last_beat;

  assign bad_width = (cfg.bw == BW_NONE);
  assign accept    = (st == ST_IDLE) && req;
  assign last_beat = (st == ST_STROBE) && (cnt == CNT_W'(1));
  assign seq_hit   = last_rd_ok && !we &&
                     (addr == last_addr + AW'(beat_bytes(cfg.bw)));
  assign strobe    = (st == ST_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      turn_len   <= '0;
      acc_we     <= 1'b0;
      acc_addr   <= '0;
      acc_wdata  <= '0;
      acc_bw     <= BW_32;
      acc_lane   <= '0;
      last_addr  <= '0;
      last_rd_ok <= 1'b0;
      hst_ready  <= 1'b0;
      hst_err    <= 1'b0;
      hst_rdata  <= '0;
    end else begin
      hst_ready <= 1'b0;
      hst_err   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (bad_width) begin
              st         <= ST_TURN;
              cnt        <= CNT_W'(1);
              turn_len   <= CNT_W'(1);
              hst_ready  <= 1'b1;
              hst_err    <= 1'b1;
              hst_rdata  <= '0;
              last_rd_ok <= 1'b0;
            end else begin
              st         <= ST_STROBE;
              cnt        <= seq_hit ? span(cfg.bur) : span(cfg.acc);
              turn_len   <= span(cfg.trn);
              acc_we     <= we;
              acc_addr   <= addr;
              acc_wdata  <= wdata;
              acc_bw     <= cfg.bw;
              acc_lane   <= lane;
              last_addr  <= addr;
              last_rd_ok <= !we;
            end
          end
        end
        ST_STROBE: begin
          if (last_beat) begin
            st        <= ST_TURN;
            cnt       <= turn_len;
            hst_ready <= 1'b1;
            hst_rdata <= acc_we ? '0 : rd_word;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_TURN: begin
          if (cnt == CNT_W'(1)) st <= ST_IDLE;
          else                  cnt <= cnt - CNT_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Checker counters: strobe length and idle gap, counted on their own.
  logic [RUN_W-1:0] strobe_run;
  logic [RUN_W-1:0] gap_run;
  logic [CNT_W-1:0] need_len;
  logic [CNT_W-1:0] gap_need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_run <= '0;
      gap_run    <= '1;
      need_len   <= '0;
      gap_need   <= '0;
    end else begin
      strobe_run <= strobe ? strobe_run + RUN_W'(1) : '0;
      if (strobe)            gap_run <= '0;
      else if (gap_run != '1) gap_run <= gap_run + RUN_W'(1);
      if (accept && !bad_width)
        need_len <= seq_hit ? span(cfg.bur) : span(cfg.acc);
      if (last_beat)                gap_need <= turn_len;
      else if (accept && bad_width) gap_need <= CNT_W'(1);
    end
  end

  // R3 / R9: a completed access held its strobes for the chosen count
  a_r3_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_ready && !hst_err) |-> (strobe_run == {1'b0, need_len}));

  // R4: ready lasts one cycle
  a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ready |=> !hst_ready);

  // R4: a data completion follows directly on a strobe cycle
  a_r4_ready_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_ready && !hst_err) |-> $past(strobe));

  // R8: a new access starts only after the turnaround has run out
  a_r8_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !$past(strobe)) |-> (gap_run >= ({1'b0, gap_need} + RUN_W'(1))));

endmodule

// File: rtl/waitstate_rom_if.sv
module waitstate_rom_if
  import wsr_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          cfg_err,
  input  logic          hst_req,
  input  logic          hst_we,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  output logic          hst_ready,
  output logic          hst_err,
  output logic [31:0]   hst_rdata,
  output logic [AW-1:0] ext_addr,
  output logic [1:0]    ext_lane,
  output logic          ext_cs_n,
  output logic          ext_oe_n,
  output logic          ext_we_n,
  output logic [31:0]   ext_dq_o,
  output logic          ext_dq_oe,
  input  logic [31:0]   ext_dq_i
);

  tcfg_t             cfg;
  logic [LANE_W-1:0] lane;
  logic              strobe;
  logic              acc_we;
  logic [AW-1:0]     acc_addr;
  logic [DW-1:0]     acc_wdata;
  bank_w_e           acc_bw;
  logic [LANE_W-1:0] acc_lane;
  logic [DW-1:0]     rd_word;

  wsr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg       (cfg),
    .lane      (lane),
    .cfg_err   (cfg_err)
  );

  wsr_fsm #(.AW(AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (hst_req),
    .we        (hst_we),
    .addr      (hst_addr),
    .wdata     (hst_wdata),
    .cfg       (cfg),
    .lane      (lane),
    .rd_word   (rd_word),
    .strobe    (strobe),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_bw    (acc_bw),
    .acc_lane  (acc_lane),
    .hst_ready (hst_ready),
    .hst_err   (hst_err),
    .hst_rdata (hst_rdata)
  );

  wsr_steer #(.AW(AW)) u_steer (
    .bw       (acc_bw),
    .lane     (acc_lane),
    .we       (acc_we),
    .addr     (acc_addr),
    .wdata    (acc_wdata),
    .dq_i     (ext_dq_i),
    .dev_addr (ext_addr),
    .dq_o     (ext_dq_o),
    .rd_word  (rd_word)
  );

  assign ext_lane  = acc_lane;
  assign ext_cs_n  = !strobe;
  assign ext_oe_n  = !(strobe && !acc_we);
  assign ext_we_n  = !(strobe && acc_we);
  assign ext_dq_oe = strobe && acc_we;

  // R2: an error completion had no device cycle before it
  a_r2_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hst_err |-> ($past(ext_cs_n) && ext_cs_n));

  // R10: write-enable only with the bus driven and output-enable off
  a_r10_we_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_we_n |-> (ext_dq_oe && ext_oe_n && !ext_cs_n));

  // R10: output-enable never while the bus is driven
  a_r10_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_oe_n |-> (!ext_dq_oe && ext_we_n));

  // R8: idle strobes leave the bus undriven
  a_r8_idle_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cs_n |-> (!ext_dq_oe && ext_oe_n && ext_we_n));

endmodule

// File: tb/waitstate_rom_if_bench.sv
module waitstate_rom_if_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic          reg_sel;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          cfg_err;
  logic          hst_req;
  logic          hst_we;
  logic [AW-1:0] hst_addr;
  logic [31:0]   hst_wdata;
  logic          hst_ready;
  logic          hst_err;
  logic [31:0]   hst_rdata;
  logic [AW-1:0] ext_addr;
  logic [1:0]    ext_lane;
  logic          ext_cs_n;
  logic          ext_oe_n;
  logic          ext_we_n;
  logic [31:0]   ext_dq_o;
  logic          ext_dq_oe;
  logic [31:0]   ext_dq_i;

  int n_tests = 0;
  int n_fail  = 0;

  waitstate_rom_if #(.AW(AW)) u_waitstate_rom_if (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_err(cfg_err),
    .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_ready(hst_ready), .hst_err(hst_err),
    .hst_rdata(hst_rdata),
    .ext_addr(ext_addr), .ext_lane(ext_lane), .ext_cs_n(ext_cs_n),
    .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n), .ext_dq_o(ext_dq_o),
    .ext_dq_oe(ext_dq_oe), .ext_dq_i(ext_dq_i)
  );

  // Device model: data is a fixed pattern of the address it sees.
  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return 32'h9E00_0000 ^ {a[7:0], a[7:0] ^ 8'h11, a[7:0] ^ 8'h22, a[7:0] ^ 8'h33};
  endfunction

  assign ext_dq_i = pat(ext_addr);

  // Control word as the requirements lay it out.
  function automatic logic [31:0] ctl(input int bw, input int acc, input int bur, input int trn);
    return (32'(trn & 15) << 24) | (32'(bur & 15) << 20) |
           (32'(acc & 15) << 16) | (32'(bw & 3) << 14);
  endfunction

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL all requirements: watchdog act=hung exp=done");
    finish_run();
  end

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  // One host access; captures the device side in its first strobe cycle.
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] wd,
                        input bit cfg_now, input logic [31:0] cfg_val,
                        output logic [31:0] rd, output logic er, output int low,
                        output logic [AW-1:0] xa, output logic [31:0] xd,
                        output logic [1:0] xl, output logic [2:0] xstb);
    @(negedge clk);
    hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = wd;
    if (cfg_now) begin
      reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = cfg_val;
    end
    low = 0; rd = 'x; er = 1'bx; xa = '0; xd = '0; xl = '0; xstb = 3'b111;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      if (!ext_cs_n) begin
        if (low == 0) begin
          xa = ext_addr; xd = ext_dq_o; xl = ext_lane;
          xstb = {ext_oe_n, ext_we_n, ext_dq_oe};
        end
        low++;
      end
      if (hst_ready) begin
        rd = hst_rdata; er = hst_err;
        break;
      end
    end
    hst_req = 1'b0;
  endtask

  task automatic rd_simple(input logic [AW-1:0] a, output logic [31:0] rd, output int low);
    logic er; logic [AW-1:0] xa; logic [31:0] xd; logic [1:0] xl; logic [2:0] xs;
    access(1'b0, a, '0, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
  endtask

  // Two reads, the second already pending when the first completes.
  task automatic back_to_back(input logic [AW-1:0] a1, input logic [AW-1:0] a2, output int g);
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b0; hst_addr = a1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (hst_ready) break;
    end
    hst_addr = a2;
    g = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      g++;
      if (!ext_cs_n) break;
    end
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (hst_ready) break;
    end
    hst_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 strobes/ready idle", {27'b0, ext_cs_n, ext_oe_n, ext_we_n, ext_dq_oe, hst_ready},
        32'b11100);
    chk("R1 cfg_err low", {31'b0, cfg_err}, 32'd0);
    reg_read(1'b0, d);
    chk("R1 control reset value", d, 32'h0000_8000);
    reg_read(1'b1, d);
    chk("R1 lane reset value", d, 32'd0);
  endtask

  task automatic t_default_read();
    logic [31:0] rd; logic er; int low; logic [AW-1:0] xa; logic [31:0] xd;
    logic [1:0] xl; logic [2:0] xs;
    access(1'b0, 24'h000104, '0, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
    chk("R3 zero access field gives 16", 32'(low), 32'd16);
    chk("R5 32-bit read data", rd, pat(24'h000104));
    chk("R4 no error on good read", {31'b0, er}, 32'd0);
    chk("R10 read strobes oe/we/dqoe", {29'b0, xs}, 32'b010);
  endtask

  task automatic t_timing();
    logic [31:0] d; logic [31:0] rd; int low;
    reg_write(1'b0, ctl(2, 3, 2, 5));
    reg_read(1'b0, d);
    chk("R3 control read-back", d, ctl(2, 3, 2, 5));
    rd_simple(24'h000300, rd, low);
    chk("R3 access wait 3", 32'(low), 32'd3);
    rd_simple(24'h000304, rd, low);
    chk("R9 sequential read uses burst 2", 32'(low), 32'd2);
    chk("R9 burst read data", rd, pat(24'h000304));
    rd_simple(24'h000308, rd, low);
    chk("R9 second burst beat", 32'(low), 32'd2);
    rd_simple(24'h000310, rd, low);
    chk("R9 skipped address uses access wait", 32'(low), 32'd3);
  endtask

  task automatic t_turnaround();
    int g;
    back_to_back(24'h000400, 24'h000500, g);
    chk("R8 turnaround 5 gap", 32'(g), 32'd6);
    reg_write(1'b0, ctl(2, 3, 2, 0));
    back_to_back(24'h000600, 24'h000700, g);
    chk("R8 zero turnaround means 16", 32'(g), 32'd17);
  endtask

  task automatic t_narrow_reads();
    logic [31:0] rd; logic er; int low; logic [AW-1:0] xa; logic [31:0] xd;
    logic [1:0] xl; logic [2:0] xs;
    reg_write(1'b0, ctl(0, 2, 2, 1));
    access(1'b0, 24'h000805, '0, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
    chk("R5 8-bit read zero-extended", rd, {24'b0, pat(24'h000805)[7:0]});
    chk("R5 read address unchanged", 32'(xa), 32'h000805);
    chk("R2 width code 00 access length", 32'(low), 32'd2);
    reg_write(1'b0, ctl(1, 2, 2, 1));
    access(1'b0, 24'h00080A, '0, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
    chk("R5 16-bit read zero-extended", rd, {16'b0, pat(24'h00080A)[15:0]});
  endtask

  task automatic t_narrow_writes();
    logic [31:0] rd; logic er; int low; logic [AW-1:0] xa; logic [31:0] xd;
    logic [1:0] xl; logic [2:0] xs;
    reg_write(1'b0, ctl(0, 2, 2, 1));
    reg_write(1'b1, 32'd3);
    access(1'b1, 24'h000907, 32'h1122_33AB, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
    chk("R6 8-bit write address aligned", 32'(xa), 32'h000904);
    chk("R6 8-bit write on lane 3", xd, 32'hAB00_0000);
    chk("R6 lane output", {30'b0, xl}, 32'd3);
    chk("R10 write strobes oe/we/dqoe", {29'b0, xs}, 32'b101);
    reg_write(1'b1, 32'd1);
    access(1'b1, 24'h000903, 32'h1122_33AB, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
    chk("R6 bus address low bits ignored", xd, 32'h0000_AB00);
    chk("R6 aligned address again", 32'(xa), 32'h000900);
    reg_write(1'b0, ctl(1, 2, 2, 1));
    reg_write(1'b1, 32'd2);
    access(1'b1, 24'h000A01, 32'h5566_7788, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
    chk("R6 16-bit write upper half", xd, 32'h7788_0000);
    chk("R6 16-bit address aligned", 32'(xa), 32'h000A00);
    reg_write(1'b1, 32'd0);
    access(1'b1, 24'h000A03, 32'h5566_7788, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
    chk("R6 16-bit write lower half", xd, 32'h0000_7788);
  endtask

  task automatic t_wide_write();
    logic [31:0] rd; logic er; int low; logic [AW-1:0] xa; logic [31:0] xd;
    logic [1:0] xl; logic [2:0] xs;
    reg_write(1'b0, ctl(2, 2, 6, 1));
    reg_write(1'b1, 32'd3);
    access(1'b1, 24'h000B03, 32'h1234_5678, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
    chk("R7 32-bit write address unchanged", 32'(xa), 32'h000B03);
    chk("R7 32-bit write full data", xd, 32'h1234_5678);
    chk("R3 write access length", 32'(low), 32'd2);
    rd_simple(24'h000B07, rd, low);
    chk("R9 read after write is not a burst", 32'(low), 32'd2);
    rd_simple(24'h000B0B, rd, low);
    chk("R9 read after read is a burst", 32'(low), 32'd6);
  endtask

  task automatic t_bad_width();
    logic [31:0] rd; logic er; int low; logic [AW-1:0] xa; logic [31:0] xd;
    logic [1:0] xl; logic [2:0] xs;
    reg_write(1'b0, ctl(3, 2, 2, 1));
    chk("R2 undefined width flagged", {31'b0, cfg_err}, 32'd1);
    access(1'b0, 24'h000C40, '0, 1'b0, '0, rd, er, low, xa, xd, xl, xs);
    chk("R2 error completion", {31'b0, er}, 32'd1);
    chk("R2 no strobe on error", 32'(low), 32'd0);
    chk("R2 error data zero", rd, 32'd0);
    reg_write(1'b0, ctl(2, 4, 2, 1));
    chk("R2 flag clears with valid width", {31'b0, cfg_err}, 32'd0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] rd; logic er; int low; logic [AW-1:0] xa; logic [31:0] xd;
    logic [1:0] xl; logic [2:0] xs;
    repeat (25) @(negedge clk);
    access(1'b0, 24'h000C00, '0, 1'b1, ctl(2, 9, 2, 1), rd, er, low, xa, xd, xl, xs);
    chk("R11 accepted access keeps old wait", 32'(low), 32'd4);
    rd_simple(24'h000D00, rd, low);
    chk("R11 next access uses new wait", 32'(low), 32'd9);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    hst_req = 1'b0; hst_we = 1'b0; hst_addr = '0; hst_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_read();
    t_timing();
    t_turnaround();
    t_narrow_reads();
    t_narrow_writes();
    t_wide_write();
    t_bad_width();
    t_same_cycle();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule